// File: doc/BRIEF.md
# Serial EEPROM Slave Emulator

This block behaves like a byte-addressed serial EEPROM on a four-wire SPI link. It samples the link pins with the system clock, splits the incoming bit stream into bytes, and decodes commands for the write-enable latch, the status byte, sequential reads and page writes. Written bytes first collect in a one-page staging buffer. When the frame ends cleanly, a self-timed busy period starts and the staged bytes are copied into the array.

During the busy period only status reads are served, so a host polls the busy bit before it sends the next command. A two-bit protection level in the status byte discards writes to the upper quarter, the upper half or the whole array. A lock bit in the same byte, together with the external write-protect pin, freezes the status byte. The system clock must run at least 8 times faster than the serial clock.

Top module: `spi_eeprom_slave`

## Requirements
- R1: Both serial-clock idle levels (low and high) work. Input bits are taken on the rising serial-clock edge and the output bit changes after a falling edge. Bytes travel MSB first.
- R2: After reset the status byte reads 0x00 and the serial output is low while the slave is deselected.
- R3: Opcode 0x06 sets the write-enable latch (status bit 1) and opcode 0x04 clears it. Each takes effect once its eighth bit has been received.
- R4: Opcode 0x05 returns the status byte in every following byte of the frame. The layout is bit 0 busy, bit 1 write-enable latch, bits 3:2 protection level, bit 7 lock, and all other bits 0. The busy bit is live.
- R5: Opcode 0x03 is followed by three address bytes, MSB first, and only the low log2(DEPTH) bits are used. Data then streams out with the address incrementing, and after the last address the stream continues at address 0.
- R6: Opcode 0x02 with the latch set is followed by three address bytes and then 1 to PAGE data bytes. Only the bytes sent change. The byte index wraps inside the addressed page.
- R7: A write or status write starts only if chip select rises on a byte boundary after at least one data byte. Otherwise the array and status stay unchanged, no busy period starts and the latch keeps its value.
- R8: Once started, busy reads 1 for WR_CYCLES system clocks. While busy, every opcode except 0x05 is ignored.
- R9: The latch clears when a write or status write completes. Opcode 0x02 or 0x01 sent while the latch is clear has no effect.
- R10: Protection level 0 protects nothing, 1 protects the top quarter of the addresses, 2 the top half and 3 the whole array. Writes to protected addresses are discarded.
- R11: Opcode 0x01 takes one data byte, which sets the protection level from bits 3:2 and the lock from bit 7. The command is rejected when the lock is 1 and the write-protect pin is low.
- R12: An unknown opcode makes the slave ignore all further bytes until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the host |
| sel_n | input | 1 | Chip select, active low |
| ser_in | input | 1 | Serial data from the host |
| ser_out | output | 1 | Serial data to the host |
| wprot_n | input | 1 | Write-protect pin, active low |

## Verification
The hardest case to reach is a command arriving while a committed write is still timing out. To reach it, the bench starts a second, fully legal write frame as soon as the first frame closes, then polls the status. It afterwards checks that the second write's target byte kept its old value. Frames that end mid-byte or right after the address are made by stopping the bit loop early. Random passes first write a region with no protection and then rewrite it under a random protection level and clock polarity, so protected bytes hold known values to compare against.

// File: rtl/spiee_pkg.sv
package spiee_pkg;
  localparam logic [7:0] OP_WEN   = 8'h06;
  localparam logic [7:0] OP_WDIS  = 8'h04;
  localparam logic [7:0] OP_RSTAT = 8'h05;
  localparam logic [7:0] OP_WSTAT = 8'h01;
  localparam logic [7:0] OP_RD    = 8'h03;
  localparam logic [7:0] OP_WR    = 8'h02;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_READ, ST_WDATA, ST_WSTAT, ST_RSTAT, ST_SKIP
  } ctl_state_t;

  // Region lock: lvl 1 -> top quarter, 2 -> top half, 3 -> all
  function automatic logic in_protected(input logic [1:0] lvl, input logic [1:0] top2);
    case (lvl)
      2'd0:    return 1'b0;
      2'd1:    return top2 == 2'b11;
      2'd2:    return top2[1];
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/spiee_link.sv
module spiee_link (
  input  logic       clk,
  input  logic       rst,
  input  logic       ser_clk,
  input  logic       sel_n,
  input  logic       ser_in,
  input  logic [7:0] tx_next,
  output logic       ser_out,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       frame_end,
  output logic       frame_aligned,
  output logic       active
);
  logic [2:0] sck_p, sel_p;
  logic [1:0] din_p;
  logic       sck_rise, sck_fall;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [6:0] tx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p <= '0;
      sel_p <= '1;
      din_p <= '0;
    end else begin
      sck_p <= {sck_p[1:0], ser_clk};
      sel_p <= {sel_p[1:0], sel_n};
      din_p <= {din_p[0], ser_in};
    end
  end

  assign sck_rise      = sck_p[1] & ~sck_p[2];
  assign sck_fall      = ~sck_p[1] & sck_p[2];
  assign active        = ~sel_p[1];
  assign frame_end     = sel_p[1] & ~sel_p[2];
  assign frame_aligned = (bit_cnt == 3'd0);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      bit_cnt  <= '0;
      rx_sh    <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (sck_rise) begin
        rx_sh   <= {rx_sh[5:0], din_p[1]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          rx_valid <= 1'b1;
          rx_byte  <= {rx_sh, din_p[1]};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      ser_out <= 1'b0;
      tx_sh   <= '0;
    end else if (sck_fall) begin
      if (bit_cnt == 3'd0) begin
        ser_out <= tx_next[7];
        tx_sh   <= tx_next[6:0];
      end else begin
        ser_out <= tx_sh[6];
        tx_sh   <= {tx_sh[5:0], 1'b0};
      end
    end
  end

  // R1: within a frame the output only moves after a falling edge
  p_out_on_fall_r1: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && !$stable(ser_out)) |-> $past(sck_fall));
  // R1: a byte is delivered only inside a frame, on a byte boundary
  p_byte_whole_r1: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (active && bit_cnt == 3'd0));
endmodule

// File: rtl/spiee_ctrl.sv
module spiee_ctrl
  import spiee_pkg::*;
#(
  parameter int AW        = 11,
  parameter int PW        = 8,
  parameter int WR_CYCLES = 400
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          frame_end,
  input  logic          frame_aligned,
  input  logic          wprot_n,
  input  logic [7:0]    rd_data,
  output logic [7:0]    tx_next,
  output logic [AW-1:0] rd_addr,
  output logic          pb_we,
  output logic [PW-1:0] pb_idx,
  output logic [7:0]    pb_wdata,
  output logic          pb_clear,
  output logic          commit_go,
  output logic [AW-PW-1:0] commit_page,
  output logic          busy,
  output logic [1:0]    bp_lvl
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  ctl_state_t    state;
  logic [CW-1:0] busy_cnt;
  logic [AW-1:0] addr_acc, addr_nx;
  logic [1:0]    abyte_cnt;
  logic          op_wr, got_data, wel, wpen;
  logic          wsr_got, wsr_wpen;
  logic [1:0]    wsr_bp;
  logic [PW-1:0] wr_ptr;
  logic [1:0]    wp_p;
  logic          wp_low;
  logic [7:0]    status_byte;

  assign busy        = (busy_cnt != '0);
  assign addr_nx     = AW'({addr_acc, rx_byte});
  assign wp_low      = ~wp_p[1];
  assign status_byte = {wpen, 3'b000, bp_lvl, wel, busy};

  always_ff @(posedge clk) begin
    if (rst) wp_p <= '1;
    else     wp_p <= {wp_p[0], wprot_n};
  end

  always_ff @(posedge clk) begin
    if (rst) tx_next <= '0;
    else     tx_next <= (state == ST_READ) ? rd_data : status_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_OPC;
      busy_cnt    <= '0;
      wel         <= 1'b0;
      wpen        <= 1'b0;
      bp_lvl      <= 2'd0;
      addr_acc    <= '0;
      abyte_cnt   <= '0;
      op_wr       <= 1'b0;
      got_data    <= 1'b0;
      wsr_got     <= 1'b0;
      wsr_wpen    <= 1'b0;
      wsr_bp      <= '0;
      wr_ptr      <= '0;
      rd_addr     <= '0;
      pb_we       <= 1'b0;
      pb_idx      <= '0;
      pb_wdata    <= '0;
      pb_clear    <= 1'b0;
      commit_go   <= 1'b0;
      commit_page <= '0;
    end else begin
      pb_we     <= 1'b0;
      pb_clear  <= 1'b0;
      commit_go <= 1'b0;
      if (busy) begin
        busy_cnt <= busy_cnt - 1'b1;
        if (busy_cnt == CW'(1)) wel <= 1'b0;
      end
      if (frame_end) begin
        if (state == ST_WDATA && got_data && frame_aligned) begin
          commit_go <= 1'b1;
          busy_cnt  <= CW'(WR_CYCLES);
        end else if (state == ST_WSTAT && wsr_got && frame_aligned) begin
          bp_lvl   <= wsr_bp;
          wpen     <= wsr_wpen;
          busy_cnt <= CW'(WR_CYCLES);
        end
        state <= ST_OPC;
      end else if (rx_valid) begin
        case (state)
          ST_OPC: begin
            if (busy) begin
              state <= (rx_byte == OP_RSTAT) ? ST_RSTAT : ST_SKIP;
            end else begin
              case (rx_byte)
                OP_WEN:   begin wel <= 1'b1; state <= ST_SKIP; end
                OP_WDIS:  begin wel <= 1'b0; state <= ST_SKIP; end
                OP_RSTAT: state <= ST_RSTAT;
                OP_WSTAT: begin
                  if (wel && !(wpen && wp_low)) begin
                    state   <= ST_WSTAT;
                    wsr_got <= 1'b0;
                  end else begin
                    state <= ST_SKIP;
                  end
                end
                OP_RD: begin
                  state     <= ST_ADDR;
                  op_wr     <= 1'b0;
                  abyte_cnt <= '0;
                end
                OP_WR: begin
                  if (wel) begin
                    state     <= ST_ADDR;
                    op_wr     <= 1'b1;
                    abyte_cnt <= '0;
                    got_data  <= 1'b0;
                    pb_clear  <= 1'b1;
                  end else begin
                    state <= ST_SKIP;
                  end
                end
                default: state <= ST_SKIP;
              endcase
            end
          end
          ST_ADDR: begin
            addr_acc  <= addr_nx;
            abyte_cnt <= abyte_cnt + 2'd1;
            if (abyte_cnt == 2'd2) begin
              if (op_wr) begin
                state       <= ST_WDATA;
                wr_ptr      <= addr_nx[PW-1:0];
                commit_page <= addr_nx[AW-1:PW];
              end else begin
                state   <= ST_READ;
                rd_addr <= addr_nx;
              end
            end
          end
          ST_READ: rd_addr <= rd_addr + 1'b1;
          ST_WDATA: begin
            pb_we    <= 1'b1;
            pb_idx   <= wr_ptr;
            pb_wdata <= rx_byte;
            wr_ptr   <= wr_ptr + 1'b1;
            got_data <= 1'b1;
          end
          ST_WSTAT: begin
            if (!wsr_got) begin
              wsr_got  <= 1'b1;
              wsr_bp   <= rx_byte[3:2];
              wsr_wpen <= rx_byte[7];
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: the latch is clear whenever a busy period has just ended
  p_wel_drop_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel);
  // R8: while busy an opcode leads only to a status read or to skipping
  p_busy_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && rx_valid && state == ST_OPC && !frame_end) |=> (state == ST_RSTAT || state == ST_SKIP));
  // R11: a locked status byte with the pin low never opens a status write
  p_lock_r11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OPC && rx_valid && !frame_end && rx_byte == OP_WSTAT && wpen && wp_low) |=> state != ST_WSTAT);
  // R10: the protection level cannot move during a busy period
  p_lvl_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(bp_lvl));
endmodule

// File: rtl/spiee_store.sv
module spiee_store
  import spiee_pkg::*;
#(
  parameter int AW = 11,
  parameter int PW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  input  logic             pb_we,
  input  logic [PW-1:0]    pb_idx,
  input  logic [7:0]       pb_wdata,
  input  logic             pb_clear,
  input  logic             commit_go,
  input  logic [AW-PW-1:0] commit_page,
  input  logic [1:0]       bp_lvl,
  input  logic             busy
);
  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PW;

  logic [7:0] mem  [DEPTH];
  logic [7:0] pbuf [PAGE];
  logic [PAGE-1:0] pb_vld;

  logic             scan_on, st_v;
  logic [PW-1:0]    scan_idx, st_idx;
  logic [7:0]       pb_q;
  logic [AW-PW-1:0] page_r;
  logic [1:0]       lvl_r;
  logic             mem_we;
  logic [AW-1:0]    mem_waddr;

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= pb_q;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (pb_we) pbuf[pb_idx] <= pb_wdata;
    pb_q <= pbuf[scan_idx];
  end

  always_ff @(posedge clk) begin
    if (rst || pb_clear) pb_vld <= '0;
    else if (pb_we)      pb_vld[pb_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_on  <= 1'b0;
      scan_idx <= '0;
      st_v     <= 1'b0;
      st_idx   <= '0;
      page_r   <= '0;
      lvl_r    <= '0;
    end else begin
      st_v   <= scan_on;
      st_idx <= scan_idx;
      if (commit_go) begin
        scan_on  <= 1'b1;
        scan_idx <= '0;
        page_r   <= commit_page;
        lvl_r    <= bp_lvl;
      end else if (scan_on) begin
        scan_idx <= scan_idx + 1'b1;
        if (scan_idx == PW'(PAGE - 1)) scan_on <= 1'b0;
      end
    end
  end

  assign mem_waddr = {page_r, st_idx};
  assign mem_we    = st_v && pb_vld[st_idx] && !in_protected(lvl_r, page_r[AW-PW-1 -: 2]);

  // R8: the array is written only inside a busy period
  p_write_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
  // R10: no array write lands in a region the live level protects
  p_no_prot_write_r10: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !in_protected(bp_lvl, mem_waddr[AW-1 -: 2]));
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int DEPTH     = 2048,
  parameter int PAGE      = 256,
  parameter int WR_CYCLES = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  input  logic sel_n,
  input  logic ser_in,
  output logic ser_out,
  input  logic wprot_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(PAGE);

  logic          rx_valid, frame_end, frame_aligned, active;
  logic [7:0]    rx_byte, tx_next, rd_data, pb_wdata;
  logic [AW-1:0] rd_addr;
  logic          pb_we, pb_clear, commit_go, busy;
  logic [PW-1:0] pb_idx;
  logic [AW-PW-1:0] commit_page;
  logic [1:0]    bp_lvl;

  spiee_link u_link (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .sel_n(sel_n), .ser_in(ser_in),
    .tx_next(tx_next), .ser_out(ser_out), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .frame_end(frame_end), .frame_aligned(frame_aligned), .active(active)
  );

  spiee_ctrl #(.AW(AW), .PW(PW), .WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .frame_end(frame_end), .frame_aligned(frame_aligned), .wprot_n(wprot_n),
    .rd_data(rd_data), .tx_next(tx_next), .rd_addr(rd_addr), .pb_we(pb_we),
    .pb_idx(pb_idx), .pb_wdata(pb_wdata), .pb_clear(pb_clear),
    .commit_go(commit_go), .commit_page(commit_page), .busy(busy), .bp_lvl(bp_lvl)
  );

  spiee_store #(.AW(AW), .PW(PW)) u_store (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data), .pb_we(pb_we),
    .pb_idx(pb_idx), .pb_wdata(pb_wdata), .pb_clear(pb_clear),
    .commit_go(commit_go), .commit_page(commit_page), .bp_lvl(bp_lvl), .busy(busy)
  );

  // R2: the output stays low while the slave is deselected
  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!active && $past(!active)) |-> !ser_out);
endmodule

// File: tb/spi_eeprom_slave_tb.sv
module spi_eeprom_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF  = 8;
  localparam int DEPTH = 2048;
  localparam int PAGE  = 256;
  localparam int WRC   = 1200;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0, rst = 1'b1;
  logic ser_clk = 1'b0, sel_n = 1'b1, ser_in = 1'b0, wprot_n = 1'b1;
  logic ser_out;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_eeprom_slave #(.DEPTH(DEPTH), .PAGE(PAGE), .WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .sel_n(sel_n), .ser_in(ser_in),
    .ser_out(ser_out), .wprot_n(wprot_n)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic cpol = 1'b0;
  logic [7:0] ref_mem [DEPTH];
  bit         known   [DEPTH];
  logic [7:0] wbuf    [PAGE];
  logic ref_wel = 0, ref_wpen = 0;
  logic [1:0] ref_bp = 0;

  function automatic bit prot(int a, logic [1:0] l);
    case (l)
      2'd0: return 0;
      2'd1: return a >= (DEPTH * 3) / 4;
      2'd2: return a >= DEPTH / 2;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] exp_status();
    return {ref_wpen, 3'b000, ref_bp, ref_wel, 1'b0};
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_start();
    @(negedge clk);
    ser_clk = cpol;
    wait_clk(HALF);
    sel_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic frame_stop();
    wait_clk(HALF);
    ser_clk = cpol;
    wait_clk(HALF);
    sel_n = 1'b1;
    wait_clk(3 * HALF);
  endtask

  task automatic xfer_bits(input logic [7:0] d, input int nb, output logic [7:0] q);
    q = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      ser_clk = 1'b0;
      ser_in  = d[i];
      wait_clk(HALF);
      q[i] = ser_out;
      ser_clk = 1'b1;
      wait_clk(HALF);
    end
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] q);
    xfer_bits(d, 8, q);
  endtask

  task automatic send_addr(input int a);
    logic [23:0] a24;
    logic [7:0] q;
    a24 = 24'($urandom);
    a24[AW-1:0] = AW'(a);
    xfer(a24[23:16], q);
    xfer(a24[15:8], q);
    xfer(a24[7:0], q);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] q;
    frame_start(); xfer(op, q); frame_stop();
  endtask

  task automatic read_status(output logic [7:0] s);
    logic [7:0] q;
    frame_start(); xfer(8'h05, q); xfer(8'h00, s); frame_stop();
  endtask

  task automatic chk_status(input string req);
    logic [7:0] s;
    read_status(s);
    chk(req, s, exp_status());
  endtask

  task automatic wait_idle();
    logic [7:0] q, s;
    bit ok = 0;
    frame_start(); xfer(8'h05, q);
    for (int k = 0; k < 60; k++) begin
      xfer(8'h00, s);
      if (!s[0]) begin ok = 1; break; end
    end
    frame_stop();
    chk("R8 busy ends", ok, 1);
  endtask

  task automatic do_write(input int a, input int n);
    logic [7:0] q;
    frame_start(); xfer(8'h02, q); send_addr(a);
    for (int i = 0; i < n; i++) xfer(wbuf[i], q);
    frame_stop();
    if (ref_wel) begin
      for (int i = 0; i < n; i++) begin
        int t;
        t = (a / PAGE) * PAGE + ((a + i) % PAGE);
        if (!prot(t, ref_bp)) begin ref_mem[t] = wbuf[i]; known[t] = 1; end
      end
      ref_wel = 0;
    end
  endtask

  task automatic do_read(input int a, input int n, input string req);
    logic [7:0] q;
    frame_start(); xfer(8'h03, q); send_addr(a);
    for (int i = 0; i < n; i++) begin
      int t;
      xfer(8'h00, q);
      t = (a + i) % DEPTH;
      if (known[t]) chk(req, q, ref_mem[t]);
    end
    frame_stop();
  endtask

  task automatic put1(input int a, input logic [7:0] v);
    cmd1(8'h06); ref_wel = 1;
    wbuf[0] = v;
    do_write(a, 1);
    wait_idle();
  endtask

  task automatic set_status(input logic [7:0] v);
    logic [7:0] q;
    cmd1(8'h06); ref_wel = 1;
    frame_start(); xfer(8'h01, q); xfer(v, q); frame_stop();
    wait_idle();
    ref_bp = v[3:2]; ref_wpen = v[7]; ref_wel = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, q;
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) known[i] = 0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);

    // R2 / R4: reset state
    chk("R2 idle output", ser_out, 0);
    chk_status("R2 R4 reset status");

    // R3: latch set and clear
    cmd1(8'h06); ref_wel = 1;
    chk_status("R3 set latch");
    cmd1(8'h04); ref_wel = 0;
    chk_status("R3 clear latch");

    // R6 with clock idling high: wrap inside a page
    cpol = 1'b1;
    cmd1(8'h06); ref_wel = 1;
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3; wbuf[3] = 8'hA4;
    do_write(PAGE + PAGE - 2, 4);
    wait_idle();
    chk_status("R9 latch cleared after write");
    do_read(PAGE + PAGE - 2, 2, "R6 page tail R1");
    do_read(PAGE, 2, "R6 page wrap R1");
    cpol = 1'b0;

    // R7: partial byte and missing data
    put1(16, 8'h55);
    cmd1(8'h06); ref_wel = 1;
    frame_start(); xfer(8'h02, q); send_addr(16); xfer(8'hAA, q); xfer_bits(8'h0F, 3, q); frame_stop();
    chk_status("R7 no start on partial byte");
    frame_start(); xfer(8'h02, q); send_addr(16); frame_stop();
    chk_status("R7 no start without data");
    do_read(16, 1, "R7 array unchanged");
    cmd1(8'h04); ref_wel = 0;

    // R9: write with latch clear
    frame_start(); xfer(8'h02, q); send_addr(16); xfer(8'h11, q); frame_stop();
    chk_status("R9 ignored without latch");
    do_read(16, 1, "R9 array unchanged");

    // R8: commands during busy
    put1(33, 8'h21);
    cmd1(8'h06); ref_wel = 1;
    wbuf[0] = 8'h77;
    do_write(32, 1);
    frame_start(); xfer(8'h02, q); send_addr(33); xfer(8'hEE, q); frame_stop();
    read_status(s);
    chk("R8 busy and latch during cycle", s, 8'h03);
    wait_idle();
    chk_status("R8 R9 after cycle");
    do_read(32, 2, "R8 write during busy dropped");

    // R5: read wraps from last address to 0
    put1(DEPTH - 1, 8'hC3);
    put1(0, 8'h3C);
    do_read(DEPTH - 1, 2, "R5 wrap to zero");

    // R12: unknown opcode swallows the rest of the frame
    frame_start(); xfer(8'hAB, q); xfer(8'h06, q); frame_stop();
    chk_status("R12 unknown opcode");

    // R11: lock plus pin blocks status write
    set_status(8'h80);
    chk_status("R11 lock set");
    wprot_n = 1'b0;
    cmd1(8'h06); ref_wel = 1;
    frame_start(); xfer(8'h01, q); xfer(8'h0C, q); frame_stop();
    chk_status("R11 rejected while pin low");
    wprot_n = 1'b1;
    frame_start(); xfer(8'h01, q); xfer(8'h00, q); frame_stop();
    wait_idle();
    ref_bp = 0; ref_wpen = 0; ref_wel = 0;
    chk_status("R11 accepted with pin high");

    // R10: whole array protected
    set_status(8'h0C);
    chk_status("R10 level 3 set");
    cmd1(8'h06); ref_wel = 1;
    wbuf[0] = 8'h99;
    do_write(16, 1);
    wait_idle();
    do_read(16, 1, "R10 all protected");
    set_status(8'h00);

    // Random passes: R1 R6 R10
    for (int it = 0; it < 8; it++) begin
      int a, n;
      logic [1:0] lvl;
      cpol = 1'($urandom % 2);
      lvl  = 2'($urandom % 4);
      a    = int'($urandom % DEPTH);
      n    = 1 + int'($urandom % 8);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      cmd1(8'h06); ref_wel = 1;
      do_write(a, n);
      wait_idle();
      set_status({4'b0000, lvl, 2'b00});
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      cmd1(8'h06); ref_wel = 1;
      do_write(a, n);
      wait_idle();
      chk_status("R10 status after random write");
      do_read(a, n, "R10 R6 random readback");
      set_status(8'h00);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule